// File: doc/BRIEF.md
# Configurable Trigger Input Deglitcher

This block cleans up one digital trigger line before other logic uses it. The raw input can first pass through a two-flop synchronizer into the local clock domain. A software-style switch selects this path or the raw pin. The selected level then goes to a single counter-based filter. A mode field sets how the filter treats edges: pass them through, take the first edge and then lock out chatter, or demand that a level hold for a programmed number of clock cycles. The hold can apply to both directions or to one direction only. A final stage can invert the result.

All settings live in one 32-bit configuration word, written through a write-enable port and readable at all times. Bits 11:0 give the filter length in cycles. Bit 12 enables the synchronizer. Bits 15:13 hold the mode. Bit 16 selects output inversion. The result `dout` is one bit in the `clk` domain.

Top module: `trig_filt`

## Requirements
- R1: Reset clears the configuration word to zero, which selects bypass with the synchronizer off and no inversion. Straight after reset, `cfg_rdata` is 0 and `dout` equals `din`.
- R2: When `cfg_we` is high at a rising edge, bits 16:0 of `cfg_wdata` are stored. From the next cycle `cfg_rdata` returns them, with bits 31:17 reading zero.
- R3: With bit 12 set, the filter sees `din` two clock edges late through a two-flop synchronizer. With bit 12 clear, the filter sees `din` directly.
- R4: With bit 16 set, `dout` is the complement of the filter result in every mode.
- R5: Mode 000 is bypass: `dout` equals the selected input with no register added. Modes 001, 010 and 011 behave exactly like 000.
- R6: Mode 100 (rapid change): a difference between the input and the held level is taken at the next edge. The following L edges then ignore the input, where L is bits 11:0.
- R7: Mode 101 (delay): the held level takes a new value only at the L-th consecutive edge at which the input differs from it. Any edge where the input matches again restarts the count. L=0 acts as L=1.
- R8: Mode 110 (stable low): a high input sets the held level at the next edge. A low input clears it only under the counting rule of R7.
- R9: Mode 111 (stable high): a low input clears the held level at the next edge. A high input sets it only under the counting rule of R7.
- R10: A configuration write clears the filter counter and leaves the held level unchanged at that edge. Counting then starts again from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to store |
| cfg_rdata | output | 32 | Stored configuration, unused bits zero |
| din | input | 1 | Raw trigger input |
| dout | output | 1 | Filtered, optionally inverted trigger |

## Verification
The assertions assume that the configuration changes only through `cfg_we`, and that reset is released on a clock edge that follows at least one edge taken in reset. The bench resets the block before each configuration. It writes the word once while `din` is low, then drives `din` at falling edges only, so the synchronizer and filter never sample a changing level. Rewrites under a live input happen only in the directed counter-restart case.

// File: rtl/trig_filt_pkg.sv
package trig_filt_pkg;
  localparam int LEN_W    = 12;
  localparam int SYNC_BIT = LEN_W;
  localparam int MODE_LO  = LEN_W + 1;
  localparam int MODE_HI  = LEN_W + 3;
  localparam int INV_BIT  = LEN_W + 4;
  localparam logic [31:0] CFG_MASK = (32'd1 << (INV_BIT + 1)) - 32'd1;

  typedef enum logic [2:0] {
    FM_BYPASS = 3'b000,
    FM_RAPID  = 3'b100,
    FM_DELAY  = 3'b101,
    FM_SLOW   = 3'b110,
    FM_SHIGH  = 3'b111
  } fmode_e;

  typedef struct packed {
    logic             inv;
    logic [2:0]       mode;
    logic             sync;
    logic [LEN_W-1:0] len;
  } fcfg_t;

  function automatic fmode_e decode_mode(input logic [2:0] raw);
    case (raw)
      3'b100:  decode_mode = FM_RAPID;
      3'b101:  decode_mode = FM_DELAY;
      3'b110:  decode_mode = FM_SLOW;
      3'b111:  decode_mode = FM_SHIGH;
      default: decode_mode = FM_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/trig_filt_sync.sv
module trig_filt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_en,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = sync_en ? chain_q[STAGES-1] : d;
endmodule

// File: rtl/trig_filt_cfg.sv
module trig_filt_cfg
  import trig_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output fcfg_t       cfg
);
  fcfg_t cfg_q;
  fcfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.len  = wdata[LEN_W-1:0];
      cfg_d.sync = wdata[SYNC_BIT];
      cfg_d.mode = wdata[MODE_HI:MODE_LO];
      cfg_d.inv  = wdata[INV_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rdata                   = '0;
    rdata[LEN_W-1:0]        = cfg_q.len;
    rdata[SYNC_BIT]         = cfg_q.sync;
    rdata[MODE_HI:MODE_LO]  = cfg_q.mode;
    rdata[INV_BIT]          = cfg_q.inv;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/trig_filt_core.sv
module trig_filt_core
  import trig_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  fmode_e           mode,
  input  logic [LEN_W-1:0] len,
  input  logic             inv,
  input  logic             sel,
  output logic             dout
);
  logic             lvl_q, lvl_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] thr;
  logic [LEN_W:0]   cnt_inc;
  logic             fast;

  assign thr     = (len == '0) ? LEN_W'(1) : len;
  assign cnt_inc = {1'b0, cnt_q} + (LEN_W+1)'(1);
  assign fast    = ((mode == FM_SLOW) && sel) || ((mode == FM_SHIGH) && !sel);

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else begin
      case (mode)
        FM_BYPASS: begin
          lvl_d = sel;
          cnt_d = '0;
        end
        FM_RAPID: begin
          if (cnt_q != '0) begin
            cnt_d = cnt_q - LEN_W'(1);
          end else if (sel != lvl_q) begin
            lvl_d = sel;
            cnt_d = len;
          end
        end
        default: begin
          if (sel == lvl_q) begin
            cnt_d = '0;
          end else if (fast || (cnt_inc >= {1'b0, thr})) begin
            lvl_d = sel;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_inc[LEN_W-1:0];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout = ((mode == FM_BYPASS) ? sel : lvl_q) ^ inv;

  // R6 R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != FM_BYPASS) |-> (cnt_q <= len));

  // R6
  rapid_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_RAPID && cnt_q != '0 && !clr) |=> $stable(lvl_q));

  // R7
  delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_DELAY && !clr && sel == lvl_q) |=> $stable(lvl_q));

  // R8
  slow_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_SLOW && !clr && sel && !lvl_q) |=> lvl_q);

  // R9
  shigh_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_SHIGH && !clr && !sel && lvl_q) |=> !lvl_q);
endmodule

// File: rtl/trig_filt.sv
module trig_filt
  import trig_filt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        din,
  output logic        dout
);
  fcfg_t  cfg;
  fmode_e mode;
  logic   sel;

  trig_filt_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  assign mode = decode_mode(cfg.mode);

  trig_filt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_en (cfg.sync),
    .d       (din),
    .q       (sel)
  );

  trig_filt_core u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_we),
    .mode  (mode),
    .len   (cfg.len),
    .inv   (cfg.inv),
    .sel   (sel),
    .dout  (dout)
  );

  // R2
  cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & CFG_MASK)));
endmodule

// File: tb/trig_filt_bench.sv
`timescale 1ns/1ps
module trig_filt_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        din;
  logic        dout;

  int n_vec  = 0;
  int n_fail = 0;

  // reference state
  int m_len, m_mode, m_sync, m_inv;
  int m_s1, m_s2, m_lvl, m_run, m_gap;

  always #2.5 clk = ~clk;

  trig_filt u_trig_filt (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .din(din), .dout(dout)
  );

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  function automatic int is_bypass(input int md);
    return (md < 4) ? 1 : 0;
  endfunction

  function automatic string tag_of();
    string t;
    case (m_mode)
      4: t = "R6";
      5: t = "R7";
      6: t = "R8";
      7: t = "R9";
      default: t = "R5";
    endcase
    if (m_sync != 0) t = {t, " R3"};
    if (m_inv != 0)  t = {t, " R4"};
    return t;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_len = 0; m_mode = 0; m_sync = 0; m_inv = 0;
    m_s1 = 0; m_s2 = 0; m_lvl = 0; m_run = 0; m_gap = 1 << 20;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; din = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle: drive at falling edge, compare, then advance the reference at the rising edge
  task automatic step(input int v, input logic we, input logic [31:0] wd, input string xtag);
    int s, thr;
    @(negedge clk);
    din = v[0]; cfg_we = we; cfg_wdata = wd;
    #1;
    s = (m_sync != 0) ? m_s2 : v;
    check({tag_of(), xtag}, int'(dout), ((is_bypass(m_mode) != 0) ? s : m_lvl) ^ m_inv);
    @(posedge clk);
    m_s2 = m_s1; m_s1 = v;
    if (we) begin
      m_len  = int'(wd[11:0]);
      m_sync = int'(wd[12]);
      m_mode = int'(wd[15:13]);
      m_inv  = int'(wd[16]);
      m_run  = 0;
      m_gap  = 1 << 20;
    end else if (is_bypass(m_mode) != 0) begin
      m_lvl = s; m_run = 0;
    end else if (m_mode == 4) begin
      if (m_gap >= m_len && s != m_lvl) begin
        m_lvl = s; m_gap = 0;
      end else begin
        m_gap++;
      end
    end else begin
      thr = (m_len == 0) ? 1 : m_len;
      if (s == m_lvl) m_run = 0;
      else begin
        m_run++;
        if (m_run >= thr || (m_mode == 6 && s == 1) || (m_mode == 7 && s == 0)) begin
          m_lvl = s; m_run = 0;
        end
      end
    end
  endtask

  int widths[18] = '{1, 1, 2, 1, 3, 2, 4, 1, 5, 3, 6, 2, 1, 7, 1, 1, 4, 4};
  int lens[5]    = '{0, 1, 2, 3, 5};

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; din = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);

    // R1: state right after reset, for both input levels
    do_reset();
    #1;
    check("R1 rdata", int'(cfg_rdata), 0);
    for (int v = 0; v < 2; v++) begin
      din = v[0];
      #1;
      check("R1 dout", int'(dout), v);
    end

    // R2: readback with junk in the unused bits
    do_reset();
    step(0, 1'b1, 32'hFFFF_5ABC, " R2");
    @(negedge clk); #1;
    check("R2 rdata", int'(cfg_rdata), int'(32'h0001_5ABC));
    step(0, 1'b1, 32'hA5A2_0000, " R2");
    @(negedge clk); #1;
    check("R2 rdata", int'(cfg_rdata), 0);

    // R3..R9: sweep of mode, synchronizer, inversion and length
    for (int md = 0; md < 8; md++)
      for (int sy = 0; sy < 2; sy++)
        for (int iv = 0; iv < 2; iv++)
          for (int li = 0; li < 5; li++) begin
            logic [31:0] w;
            int lv;
            w = 32'(lens[li]) | (32'(sy) << 12) | (32'(md) << 13) | (32'(iv) << 16);
            do_reset();
            step(0, 1'b1, w, "");
            step(0, 1'b0, '0, "");
            step(0, 1'b0, '0, "");
            lv = 1;
            for (int k = 0; k < 18; k++) begin
              for (int c = 0; c < widths[k]; c++) step(lv, 1'b0, '0, "");
              lv = 1 - lv;
            end
            for (int c = 0; c < 8; c++) step(0, 1'b0, '0, "");
          end

    // R10: rewriting the word while a level is being counted restarts the count
    do_reset();
    step(0, 1'b1, 32'h0000_A004, " R10");
    step(1, 1'b0, '0, " R10");
    step(1, 1'b0, '0, " R10");
    step(1, 1'b0, '0, " R10");
    step(1, 1'b1, 32'h0000_A004, " R10");
    for (int c = 0; c < 6; c++) step(1, 1'b0, '0, " R10");
    step(0, 1'b0, '0, " R10");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule